// File: doc/BRIEF.md
# Scatter-gather descriptor generator

This block turns a stream of memory segments, each an address and a byte length, into a list of fixed-size DMA descriptors. It writes that list into a descriptor table through a simple memory port. A descriptor may not span a 64 KiB address boundary, so a segment that crosses one or more such boundaries is cut into several chunks. Each chunk becomes one descriptor of four 32-bit words, stored byte-swapped (big-endian).

Segments arrive on a valid/ready handshake, and `seg_last_i` marks the final segment of a list. The block works on one list at a time. Once the whole list has been written, it reads back the length word of the final descriptor, sets the end-of-list flag in it and writes it again. It then pulses `done_o` with the descriptor count and a success flag. A count of zero with `ok_o` low tells the caller to fall back to programmed I/O. This happens when the list produced no descriptors, or when the table ran out of entries.

Top module: `sg_desc_gen`

## Requirements
- R1: Each chunk is 0x10000 minus the low 16 bits of the current address, capped at the bytes left in the segment. The address then advances by the chunk and the remaining length shrinks by it, so no descriptor crosses a 64 KiB boundary.
- R2: Descriptor k occupies table word addresses 4k to 4k+3. Word 0 and word 2 are zero. Word 1 is the chunk address. Word 3 holds the chunk length in bits 15:0 and zeros in bits 30:16. Every word is byte-swapped before it is written, so value bit 31 lands in stored bit 7.
- R3: A chunk of exactly 65536 bytes is encoded with a length field of 0.
- R4: After the last descriptor of a successful list is written, its word 3 is read (`tbl_re_o`, data on `tbl_rdata_i` one cycle later). In the next cycle it is written back with value bit 31 set. No other descriptor carries that bit.
- R5: `done_o` is high for exactly one cycle per list. `count_o` and `ok_o` are valid in that cycle.
- R6: A list that needs more than MAX_DESC descriptors aborts: `ok_o`=0 and `count_o`=0. A list that needs exactly MAX_DESC descriptors succeeds with `count_o`=MAX_DESC.
- R7: A list that yields no descriptors (its first segment has length 0) reports `ok_o`=0 and `count_o`=0.
- R8: A zero-length segment ends descriptor generation for its list. Any further segments, up to and including the one with `seg_last_i`, are accepted and discarded without table writes. The same applies after an abort.
- R9: `seg_ready_o` is high only while the block waits for a segment. It is low while descriptors are being emitted, and no table access occurs while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| seg_valid_i | input | 1 | Segment offered |
| seg_ready_o | output | 1 | Segment accepted when high with valid |
| seg_addr_i | input | 32 | Segment start address |
| seg_len_i | input | 32 | Segment length in bytes |
| seg_last_i | input | 1 | Final segment of the list |
| tbl_we_o | output | 1 | Table write strobe |
| tbl_re_o | output | 1 | Table read strobe |
| tbl_addr_o | output | log2(MAX_DESC)+2 | Table word address |
| tbl_wdata_o | output | 32 | Table write data (stored byte order) |
| tbl_rdata_i | input | 32 | Table read data, one cycle after tbl_re_o |
| done_o | output | 1 | List finished, one-cycle pulse |
| ok_o | output | 1 | List succeeded |
| count_o | output | log2(MAX_DESC+1) | Descriptors in the list, 0 on failure |

## Verification
The checker watches the word layout on every cycle. The zero words must be zero, the length word must keep its upper value bits clear, and the end-of-list write must equal the word just read with the flag OR-ed in. It also checks that `done_o` is a single-cycle pulse, that a failed result carries a zero count, and that the table is never touched while a segment can be accepted. Only the bench scenarios can show the chunk split points across boundaries and the encoding of a full 64 KiB chunk. The same holds for the exact limit against one descriptor too many, the draining of segments after a zero length or an abort, and the absence of stray writes past the end of the list.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_EMIT, ST_DRAIN, ST_FIN, ST_RD, ST_WR, ST_DONE
  } sg_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction
endpackage

// File: rtl/sg_chunk.sv
module sg_chunk (
  input  logic [15:0] addr_lo_i,
  input  logic [31:0] rem_i,
  output logic [31:0] chunk_o
);
  logic [16:0] span;
  assign span    = 17'h10000 - {1'b0, addr_lo_i};
  assign chunk_o = (rem_i < {15'b0, span}) ? rem_i : {15'b0, span};
endmodule

// File: rtl/sg_desc_word.sv
module sg_desc_word #(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [1:0]  sel_i,
  input  logic [31:0] addr_i,
  input  logic [15:0] len_i,
  output logic [31:0] word_o
);
  logic [31:0] val;
  always_comb begin
    unique case (sel_i)
      2'd1:    val = addr_i;
      2'd3:    val = {16'b0, len_i};
      default: val = '0;
    endcase
  end

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign word_o = sg_pkg::bswap32(val);
    end else begin : g_native
      assign word_o = val;
    end
  endgenerate
endmodule

// File: rtl/sg_desc_gen.sv
module sg_desc_gen #(
  parameter int unsigned MAX_DESC   = 64,
  parameter bit          BIG_ENDIAN = 1'b1,
  localparam int unsigned CNT_W     = $clog2(MAX_DESC + 1),
  localparam int unsigned TBL_AW    = $clog2(MAX_DESC) + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seg_valid_i,
  output logic              seg_ready_o,
  input  logic [31:0]       seg_addr_i,
  input  logic [31:0]       seg_len_i,
  input  logic              seg_last_i,
  output logic              tbl_we_o,
  output logic              tbl_re_o,
  output logic [TBL_AW-1:0] tbl_addr_o,
  output logic [31:0]       tbl_wdata_o,
  input  logic [31:0]       tbl_rdata_i,
  output logic              done_o,
  output logic              ok_o,
  output logic [CNT_W-1:0]  count_o
);
  import sg_pkg::*;

  localparam logic [31:0] EOL_MASK = BIG_ENDIAN ? 32'h0000_0080 : 32'h8000_0000;

  sg_state_e        state_q;
  logic [31:0]      addr_q, rem_q, chunk;
  logic [CNT_W-1:0] cnt_q, res_cnt_q;
  logic [1:0]       widx_q;
  logic             last_q, fail_q, ok_q;
  logic [31:0]      desc_word;
  logic             accept, full;

  sg_chunk u_chunk (
    .addr_lo_i (addr_q[15:0]),
    .rem_i     (rem_q),
    .chunk_o   (chunk)
  );

  sg_desc_word #(.BIG_ENDIAN(BIG_ENDIAN)) u_word (
    .sel_i  (widx_q),
    .addr_i (addr_q),
    .len_i  (chunk[15:0]),
    .word_o (desc_word)
  );

  assign seg_ready_o = (state_q == ST_IDLE) || (state_q == ST_DRAIN);
  assign accept      = seg_valid_i && seg_ready_o;
  assign full        = (cnt_q == CNT_W'(MAX_DESC));

  always_comb begin
    tbl_we_o    = 1'b0;
    tbl_re_o    = 1'b0;
    tbl_addr_o  = TBL_AW'({cnt_q, widx_q});
    tbl_wdata_o = desc_word;
    unique case (state_q)
      ST_EMIT: tbl_we_o = !(widx_q == 2'd0 && full);
      ST_RD: begin
        tbl_re_o   = 1'b1;
        tbl_addr_o = TBL_AW'({cnt_q - CNT_W'(1), 2'b11});
      end
      ST_WR: begin
        tbl_we_o    = 1'b1;
        tbl_addr_o  = TBL_AW'({cnt_q - CNT_W'(1), 2'b11});
        tbl_wdata_o = tbl_rdata_i | EOL_MASK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      res_cnt_q <= '0;
      widx_q    <= '0;
      last_q    <= 1'b0;
      fail_q    <= 1'b0;
      ok_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q <= seg_addr_i;
          rem_q  <= seg_len_i;
          last_q <= seg_last_i;
          widx_q <= '0;
          if (seg_len_i == '0) state_q <= seg_last_i ? ST_FIN : ST_DRAIN;
          else                 state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (widx_q == 2'd0 && full) begin
            fail_q  <= 1'b1;
            state_q <= last_q ? ST_FIN : ST_DRAIN;
          end else begin
            widx_q <= widx_q + 2'd1;
            if (widx_q == 2'd3) begin
              cnt_q  <= cnt_q + CNT_W'(1);
              addr_q <= addr_q + chunk;
              rem_q  <= rem_q - chunk;
              if (rem_q == chunk) state_q <= last_q ? ST_FIN : ST_IDLE;
            end
          end
        end
        ST_DRAIN: if (accept && seg_last_i) state_q <= ST_FIN;
        ST_FIN: begin
          if (fail_q || cnt_q == '0) begin
            ok_q      <= 1'b0;
            res_cnt_q <= '0;
            state_q   <= ST_DONE;
          end else begin
            ok_q      <= 1'b1;
            res_cnt_q <= cnt_q;
            state_q   <= ST_RD;
          end
        end
        ST_RD:   state_q <= ST_WR;
        ST_WR:   state_q <= ST_DONE;
        ST_DONE: begin
          cnt_q   <= '0;
          fail_q  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o  = (state_q == ST_DONE);
  assign ok_o    = ok_q;
  assign count_o = res_cnt_q;
endmodule

// File: rtl/sg_desc_gen_chk.sv
module sg_desc_gen_chk #(
  parameter int unsigned MAX_DESC   = 64,
  parameter bit          BIG_ENDIAN = 1'b1,
  localparam int unsigned CNT_W     = $clog2(MAX_DESC + 1),
  localparam int unsigned TBL_AW    = $clog2(MAX_DESC) + 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              seg_ready_o,
  input logic              tbl_we_o,
  input logic              tbl_re_o,
  input logic [TBL_AW-1:0] tbl_addr_o,
  input logic [31:0]       tbl_wdata_o,
  input logic [31:0]       tbl_rdata_i,
  input logic              done_o,
  input logic              ok_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [31:0] EOL_MASK = BIG_ENDIAN ? 32'h0000_0080 : 32'h8000_0000;

  // R2
  zero_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o && !tbl_addr_o[0]) |-> tbl_wdata_o == 32'h0);

  // R2
  len_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_we_o && tbl_addr_o[1:0] == 2'b11 && !$past(tbl_re_o)) |->
    ((BIG_ENDIAN ? tbl_wdata_o[15:0] : tbl_wdata_o[31:16]) == 16'h0));

  // R4
  eol_rmw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tbl_re_o) |-> (tbl_we_o && tbl_wdata_o == (tbl_rdata_i | EOL_MASK)
                         && tbl_addr_o == $past(tbl_addr_o)));

  // R4
  rd_len_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_re_o |-> (tbl_addr_o[1:0] == 2'b11 && !tbl_we_o));

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  fail_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ok_o) |-> count_o == '0);

  // R6
  count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ok_o) |-> (count_o != '0 && count_o <= CNT_W'(MAX_DESC)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_ready_o |-> (!tbl_we_o && !tbl_re_o));
endmodule

bind sg_desc_gen sg_desc_gen_chk #(.MAX_DESC(MAX_DESC), .BIG_ENDIAN(BIG_ENDIAN)) u_chk (.*);

// File: tb/sg_desc_gen_test.sv
module sg_desc_gen_test;
  localparam int MAX = 64;
  localparam int CW  = $clog2(MAX + 1);
  localparam int AW  = $clog2(MAX) + 2;
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  logic clk = 0, rst_n = 0;
  logic seg_valid = 0, seg_last = 0;
  logic [31:0] seg_addr = 0, seg_len = 0;
  logic seg_ready, we, re, done, ok;
  logic [AW-1:0] taddr;
  logic [31:0] wdata, rdata;
  logic [CW-1:0] count;

  logic [31:0] mem [MAX*4];
  int checks = 0, fails = 0, done_seen = 0;
  logic [31:0] sa[$], sl[$], ea[$], el[$];
  logic [CW:0] res_q[$];  // {ok, count}
  string tag;

  always #10 clk = ~clk;

  sg_desc_gen #(.MAX_DESC(MAX)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .seg_valid_i(seg_valid), .seg_ready_o(seg_ready),
    .seg_addr_i(seg_addr), .seg_len_i(seg_len), .seg_last_i(seg_last),
    .tbl_we_o(we), .tbl_re_o(re), .tbl_addr_o(taddr),
    .tbl_wdata_o(wdata), .tbl_rdata_i(rdata),
    .done_o(done), .ok_o(ok), .count_o(count)
  );

  always @(posedge clk) begin
    if (we) mem[taddr] <= wdata;
    if (re) rdata <= mem[taddr];
  end

  function automatic logic [31:0] be(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pop expected result on each done pulse and compare table
  always @(negedge clk) begin
    if (rst_n && done) begin
      logic [CW:0] e;
      e = res_q.pop_front();
      chk({tag, " R5 R6 R7 ok/count"}, {ok, count}, e);
      if (e[CW]) begin
        for (int k = 0; k < int'(e[CW-1:0]); k++) begin
          logic [31:0] lw;
          lw = {(k == int'(e[CW-1:0]) - 1), 15'b0, el[k][15:0]};
          chk({tag, " R1 R2 R3 R4 descriptor"},
              {mem[4*k] | mem[4*k+2], be(mem[4*k+1]) ^ be(mem[4*k+3])},
              {32'h0, ea[k] ^ lw});
        end
        if (int'(e[CW-1:0]) < MAX)
          chk({tag, " R8 no write past list"}, {32'h0, mem[4*int'(e[CW-1:0])]}, {32'h0, SENT});
      end
      done_seen++;
    end
  end

  task automatic run_list(input string name, input bit probe_busy);
    bit fail = 0;
    int base;
    tag = name;
    ea.delete(); el.delete();
    for (int i = 0; i < sa.size(); i++) begin
      logic [31:0] a, r, c;
      if (sl[i] == 0) break;
      a = sa[i]; r = sl[i];
      while (r != 0) begin
        if (ea.size() == MAX) begin fail = 1; break; end
        c = 32'h10000 - {16'h0, a[15:0]};
        if (c > r) c = r;
        ea.push_back(a); el.push_back(c);
        a += c; r -= c;
      end
      if (fail) break;
    end
    if (!fail && ea.size() > 0) res_q.push_back({1'b1, CW'(ea.size())});
    else                        res_q.push_back('0);
    for (int w = 0; w < MAX*4; w++) mem[w] = SENT;
    base = done_seen;
    for (int i = 0; i < sa.size(); i++) begin
      @(negedge clk);
      seg_valid = 1; seg_addr = sa[i]; seg_len = sl[i]; seg_last = (i == sa.size() - 1);
      while (!seg_ready) @(negedge clk);
      @(negedge clk);
      seg_valid = 0;
      if (probe_busy && i == 0) chk({name, " R9 busy while emitting"}, {63'h0, seg_ready}, 64'h0);
    end
    while (done_seen == base) @(negedge clk);
    sa.delete(); sl.delete();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset ready", {62'h0, seg_ready, done}, 64'h2);
    rst_n = 1;
    @(negedge clk);

    sa = '{32'h1000_0000}; sl = '{32'h200};
    run_list("single", 0);

    sa = '{32'h0001_FF00}; sl = '{32'h300};
    run_list("cross", 0);

    sa = '{32'h0002_0000}; sl = '{32'h1_0000};
    run_list("full64k R3", 0);

    sa = '{32'h0000_8000}; sl = '{32'h3_0000};
    run_list("multi", 1);

    sa = '{32'h4000_0010, 32'h4001_FFFC, 32'h7000_0000};
    sl = '{32'h40, 32'h8, 32'h1_0001};
    run_list("list", 0);

    sa = '{32'h1000, 32'h2000, 32'h5000}; sl = '{32'h100, 32'h0, 32'h100};
    run_list("zero mid R8", 0);

    sa = '{32'h1000}; sl = '{32'h0};
    run_list("empty R7", 0);

    sa = '{32'h0100_0000}; sl = '{32'h40_0000};
    run_list("exact max R6", 0);

    sa = '{32'h0200_0000, 32'h0900_0000}; sl = '{32'h41_0000, 32'h100};
    run_list("overflow R6", 0);

    sa = '{32'h0300_0000, 32'h0400_0000}; sl = '{32'h3F_0000, 32'h2_0000};
    run_list("overflow tail R6", 0);

    sa = '{32'h0000_FFFF}; sl = '{32'h2};
    run_list("after abort", 0);

    finish_up();
  end
endmodule